// File: doc/BRIEF.md
# Byte-to-Halfword Write Packer

The packer accepts a write request made of a byte start address and a 16-bit byte count. It then takes that many bytes from a byte stream and turns them into 16-bit writes toward a memory port that can only store whole halfwords. Every halfword write goes to an even address.

Two bytes that share an aligned halfword are packed little-endian and written directly. A byte that has no partner is merged through a read-modify-write, so the other half of its halfword keeps the value it already holds. Such a lone byte is either the first byte of a request that starts at an odd address or the last byte of an odd-length remainder. For the merge the packer first reads the halfword back, puts the new byte into the half that belongs to it, and then writes the result.

A request is accepted only while the block is idle. A one-cycle done pulse marks the end of the request, and it comes only after the final write has been acknowledged.

Top module: `hwp_top`

## Requirements
- R1: After reset, req_ready is 1 and done, in_ready, rd_req and wr_req are all 0.
- R2: A lone byte B at an odd address A first reads the halfword at A-1. It then writes {B, read[7:0]} (B in bits 15:8) to address A-1.
- R3: A lone byte B at an even address A first reads the halfword at A. It then writes {read[15:8], B} (B in bits 7:0) to address A.
- R4: When the start address is odd, the first byte is written alone by the merge method of R2. The remaining length-1 bytes continue from the next even address.
- R5: While two or more bytes remain at an even address, the packer writes them as one halfword without reading: the earlier byte in bits 7:0, the later byte in bits 15:8. The address then advances by 2.
- R6: A single byte that remains at the end is written alone by the merge method of R3.
- R7: A request of length 0 makes no reads and no writes and still produces done.
- R8: Bit 0 of rd_addr is 0 whenever rd_req is 1, and bit 0 of wr_addr is 0 whenever wr_req is 1.
- R9: done is a one-cycle pulse that follows the acknowledgement of the last write. req_ready is 1 only while idle, so no request is taken while one is in progress.
- R10: Exactly len bytes are consumed from the stream, in ascending address order.
- R11: Once raised, wr_req, wr_addr and wr_data stay unchanged until wr_done. rd_req and rd_addr likewise stay unchanged until rd_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | AW | Byte start address |
| req_len | input | LW | Byte count |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Packer takes the byte this cycle |
| in_data | input | 8 | Stream byte |
| rd_req | output | 1 | Halfword read request |
| rd_addr | output | AW | Read byte address, even |
| rd_done | input | 1 | Read complete, rd_data valid |
| rd_data | input | 16 | Halfword read back |
| wr_req | output | 1 | Halfword write request |
| wr_addr | output | AW | Write byte address, even |
| wr_data | output | 16 | Halfword to store |
| wr_done | input | 1 | Write accepted |
| done | output | 1 | Request finished pulse |

## Verification
The bench goes after the cases where the alignment decides the path.

- Odd starts with length 1, 2 and 3, even starts with odd lengths, the last byte of the memory, and zero length are each driven directly. Random requests with random memory latencies and stream gaps come on top.
- A merge into the wrong half, or a merge that skips the read, would overwrite a neighbouring byte in the reference memory image.
- Swapped pair packing would reverse byte order in the image.
- A wrong split between lone and paired bytes would change the expected read and write counts.
- A done that comes too early would let the memory comparison run before the last write has landed.

// File: rtl/hwp_pkg.sv
package hwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_FETCH,
        ST_STORE,
        ST_FINISH
    } hwp_state_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } halfword_t;

    // Place a new byte into the half selected by the byte address parity,
    // keeping the other half from the value read back.
    function automatic halfword_t merge_byte(input logic odd,
                                             input logic [7:0] nb,
                                             input halfword_t old);
        halfword_t r;
        if (odd) begin
            r.hi = nb;
            r.lo = old.lo;
        end else begin
            r.hi = old.hi;
            r.lo = nb;
        end
        return r;
    endfunction

endpackage

// File: rtl/hwp_cursor.sv
module hwp_cursor #(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [LW-1:0] load_len,
    input  logic          advance,
    output logic [AW-1:0] cur_addr,
    output logic          lone,
    output logic          empty
);
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic [LW-1:0] step;

    assign lone     = addr_q[0] || (rem_q == LW'(1));
    assign empty    = (rem_q == '0);
    assign cur_addr = addr_q;
    assign step     = lone ? LW'(1) : LW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            rem_q  <= load_len;
        end else if (advance) begin
            addr_q <= addr_q + AW'(step);
            rem_q  <= rem_q - step;
        end
    end
endmodule

// File: rtl/hwp_assembler.sv
module hwp_assembler
    import hwp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic [7:0] byte_in,
    input  logic       merge,
    input  logic       odd,
    input  halfword_t  old_word,
    input  logic       clear,
    output logic       have_one,
    output halfword_t  word
);
    halfword_t hold_q;
    logic      cnt_q;

    assign have_one = cnt_q;
    assign word     = hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            cnt_q  <= 1'b0;
        end else begin
            if (take) begin
                if (!cnt_q) hold_q.lo <= byte_in;
                else        hold_q.hi <= byte_in;
                cnt_q <= ~cnt_q;
            end else if (merge) begin
                hold_q <= merge_byte(odd, hold_q.lo, old_word);
            end
            if (clear) cnt_q <= 1'b0;
        end
    end
endmodule

// File: rtl/hwp_top.sv
module hwp_top
    import hwp_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_done,
    input  logic [15:0]   rd_data,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [15:0]   wr_data,
    input  logic          wr_done,
    output logic          done
);
    hwp_state_e state_q, state_d;

    logic [AW-1:0] cur_addr;
    logic          lone, empty, have_one;
    logic          load, advance, take, merge;
    halfword_t     word;
    logic [AW-1:0] even_addr;

    assign even_addr = {cur_addr[AW-1:1], 1'b0};

    hwp_cursor #(.AW(AW), .LW(LW)) u_cursor (
        .clk(clk), .rst(rst),
        .load(load), .load_addr(req_addr), .load_len(req_len),
        .advance(advance),
        .cur_addr(cur_addr), .lone(lone), .empty(empty)
    );

    hwp_assembler u_asm (
        .clk(clk), .rst(rst),
        .take(take), .byte_in(in_data),
        .merge(merge), .odd(cur_addr[0]), .old_word(halfword_t'(rd_data)),
        .clear(advance),
        .have_one(have_one), .word(word)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign in_ready  = (state_q == ST_GATHER) && !empty;
    assign rd_req    = (state_q == ST_FETCH);
    assign wr_req    = (state_q == ST_STORE);
    assign done      = (state_q == ST_FINISH);
    assign rd_addr   = even_addr;
    assign wr_addr   = even_addr;
    assign wr_data   = word;

    assign load    = req_ready && req_valid;
    assign take    = in_ready && in_valid;
    assign merge   = rd_req && rd_done;
    assign advance = wr_req && wr_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_GATHER;
            ST_GATHER: begin
                if (empty)              state_d = ST_FINISH;
                else if (take && lone)  state_d = ST_FETCH;
                else if (take && have_one) state_d = ST_STORE;
            end
            ST_FETCH:  if (rd_done) state_d = ST_STORE;
            ST_STORE:  if (wr_done) state_d = ST_GATHER;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/hwp_check.sv
module hwp_check #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          in_ready,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_done,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic [15:0]   wr_data,
    input logic          wr_done,
    input logic          done
);
    // R8
    wr_even_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> !wr_addr[0]);
    // R8
    rd_even_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> !rd_addr[0]);
    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_done) |=> (rd_req && $stable(rd_addr)));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));
    // R9
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req || wr_req || in_ready || done) |-> !req_ready);
    // R11
    excl_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({rd_req, wr_req, in_ready}) <= 1);
endmodule

bind hwp_top hwp_check #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .in_ready(in_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_done(wr_done), .done(done)
);

// File: tb/hwp_top_test.sv
module hwp_top_test;
    localparam int AW = 16;
    localparam int LW = 16;
    localparam int MB = 512;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_ready;
    logic [AW-1:0] req_addr = 0;
    logic [LW-1:0] req_len = 0;
    logic in_valid = 0, in_ready;
    logic [7:0] in_data = 0;
    logic rd_req, rd_done = 0;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [15:0] rd_data = 0, wr_data;
    logic wr_req, wr_done = 0, done;

    int n_checks = 0, n_fail = 0;
    int n_reads = 0, n_writes = 0, n_consumed = 0;
    logic [7:0] mem [MB];
    logic [7:0] model [MB];
    logic [7:0] stream [MB];
    int stream_len = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hwp_top #(.AW(AW), .LW(LW)) uut (.*);

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory responders, driven at negedge so signals settle before posedge
    initial begin
        forever begin
            @(negedge clk);
            if (rd_done) rd_done = 0;
            else if (rd_req && ($urandom % 3 == 0)) begin
                rd_data = {mem[{rd_addr[8:1], 1'b1}], mem[{rd_addr[8:1], 1'b0}]};
                rd_done = 1;
                n_reads++;
            end
            if (wr_done) wr_done = 0;
            else if (wr_req && ($urandom % 3 == 0)) begin
                mem[{wr_addr[8:1], 1'b0}] = wr_data[7:0];
                mem[{wr_addr[8:1], 1'b1}] = wr_data[15:8];
                wr_done = 1;
                n_writes++;
            end
        end
    end

    // byte source
    initial begin
        bit fire = 0;
        forever begin
            @(negedge clk);
            if (fire) n_consumed++;
            in_valid = (n_consumed < stream_len) && ($urandom % 4 != 0);
            in_data  = (n_consumed < MB) ? stream[n_consumed] : 8'h00;
            fire = in_valid && in_ready;
        end
    end

    function automatic int exp_reads(input int a, input int l);
        int r = 0;
        if (l == 0) return 0;
        if (a % 2 == 1) begin r++; l--; end
        if (l % 2 == 1) r++;
        return r;
    endfunction

    function automatic int exp_writes(input int a, input int l);
        int r = 0;
        if (l == 0) return 0;
        if (a % 2 == 1) begin r++; l--; end
        return r + (l + 1) / 2;
    endfunction

    task automatic run(input int a, input int l, input string tag);
        int wait_cnt = 0;
        int dones = 0;
        bit mem_ok = 1;
        int bad = 0;
        for (int i = 0; i < MB; i++) begin
            mem[i] = 8'($urandom);
            model[i] = mem[i];
        end
        for (int i = 0; i < l; i++) begin
            stream[i] = 8'($urandom);
            model[a + i] = stream[i];
        end
        @(negedge clk);
        n_reads = 0; n_writes = 0; n_consumed = 0; stream_len = l;
        req_addr = AW'(a); req_len = LW'(l); req_valid = 1;
        check({tag, " R9 idle ready"}, req_ready == 1, req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        while (wait_cnt < 20000) begin
            if (done) dones++;
            @(negedge clk);
            wait_cnt++;
            if (dones > 0) break;
        end
        repeat (3) begin
            if (done) dones++;
            @(negedge clk);
        end
        check({tag, " R9 single done"}, dones == 1, dones, 1);
        for (int i = 0; i < MB; i++)
            if (mem[i] !== model[i]) begin mem_ok = 0; bad = i; end
        check({tag, " R2 R3 R4 R5 R6 memory image"}, mem_ok, mem[bad], model[bad]);
        check({tag, " R7 R4 R6 reads"}, n_reads == exp_reads(a, l), n_reads, exp_reads(a, l));
        check({tag, " R5 R7 writes"}, n_writes == exp_writes(a, l), n_writes, exp_writes(a, l));
        check({tag, " R10 consumed"}, n_consumed == l, n_consumed, l);
        stream_len = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check("R1 reset ready", req_ready == 1, req_ready, 1);
        check("R1 reset quiet", {done, in_ready, rd_req, wr_req} == 4'b0,
              {done, in_ready, rd_req, wr_req}, 0);
        run(5, 1, "odd lone R2");
        run(8, 1, "even lone R3");
        run(7, 2, "odd len2 R4");
        run(10, 2, "even pair R5");
        run(3, 3, "odd len3 R4 R6");
        run(12, 5, "even tail R6");
        run(20, 0, "zero R7");
        run(511, 1, "top byte R2");
        run(0, 512, "full R5");
        run(1, 511, "odd full R4");
        for (int k = 0; k < 60; k++) begin
            int a = $urandom % MB;
            int l = $urandom % 41;
            if (a + l > MB) l = MB - a;
            run(a, l, "random R10");
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog R9 actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule